// File: doc/BRIEF.md
# Line-Buffered Camera Stream Emulator

This block stands in for an image sensor during bring-up of a downstream pixel consumer. A host pushes one image line into an internal line buffer through a byte-wide write port. Once the whole line is held and streaming is permitted, the block plays the line out one pixel at a time. Each pixel comes with a generated pixel clock, a row-valid flag and, for the first pixel of a frame, a frame-start flag.

After each line the block inserts a programmable blanking gap. It then waits until the host has delivered the next complete line. The pace of line output therefore follows the host's fill rate plus the gap. Column and row counters track the position of the pixel on the output. Run, halt and one-line commands decide whether a buffered line may be played.

Top module: `cam_line_replay`

## Requirements
- R1: After reset, rsync_o, fsync_o and pclk_o are 0, x_o and y_o are 0, and state_o is 0.
- R2: No pixel of a line is emitted until all LINE_PIX bytes of that line have been written.
- R3: Each pixel occupies two clock cycles, with pclk_o low in the first and high in the second. pix_o and x_o stay constant across both cycles. The pixels leave in write order: the first byte written is at x_o = 0.
- R4: rsync_o is high for exactly 2*LINE_PIX consecutive cycles per line, and pclk_o is never high outside that window.
- R5: fsync_o is high only during the two cycles of the pixel at x_o = 0, y_o = 0.
- R6: After a line, rsync_o stays low for gap_cfg_i+1 cycles when the next line is already complete. The gap value is sampled in the last cycle of the line.
- R7: With streaming permitted, the final write that completes a line is followed by rsync_o rising two cycles after that write's cycle.
- R8: A write while the buffer holds a complete unsent line is refused. wr_rej_o pulses high for one cycle in the cycle after that write, and the buffered pixels are not altered.
- R9: start_i enables continuous playback. stop_i (which wins over start_i) withholds every further line, but a line already in progress completes.
- R10: single_i permits exactly one buffered line to be played. A later complete line stays held.
- R11: x_o wraps from LINE_PIX-1 to 0 at the end of each line and y_o then increments. y_o wraps from ROWS-1 to 0, so the next line carries fsync_o again.
- R12: state_o reports 0 while waiting for a line or for permission, 1 while emitting and 2 during the gap. x_o and y_o always stay below LINE_PIX and ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | PIX_W | Host pixel byte, stored at the next buffer slot |
| wr_rej_o | output | 1 | Pulse: previous write refused (buffer full) |
| start_i | input | 1 | Enable continuous playback |
| stop_i | input | 1 | Withhold further lines |
| single_i | input | 1 | Permit one line |
| gap_cfg_i | input | GAP_W | Blanking gap length in cycles |
| pix_o | output | PIX_W | Pixel value |
| pclk_o | output | 1 | Generated pixel clock |
| rsync_o | output | 1 | Row valid |
| fsync_o | output | 1 | Frame start (first pixel of frame) |
| x_o | output | $clog2(LINE_PIX) | Column of current pixel |
| y_o | output | $clog2(ROWS) | Row of current line |
| state_o | output | 2 | 0 wait, 1 emit, 2 gap |

## Verification
Buffer release and a host write can land in the same cycle, because the next line is written during the blanking gap of the previous one. The bench provokes this by starting the next line's writes on the first low cycle of rsync_o. It then judges that every byte was taken (the following line plays those exact bytes) and that the low time equals the gap plus one. A refused write against a full, held buffer is judged by wr_rej_o and by the unchanged pixels of the line that plays next.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_EMIT = 2'd1,
    ST_GAP  = 2'd2
  } cam_st_e;
endpackage

// File: rtl/cam_linebuf.sv
module cam_linebuf #(
  parameter int LINE_PIX = 752,
  parameter int PIX_W    = 8,
  localparam int XW      = $clog2(LINE_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PIX_W-1:0] wr_data_i,
  input  logic             release_i,
  input  logic [XW-1:0]    rd_idx_i,
  output logic [PIX_W-1:0] rd_data_o,
  output logic             full_o,
  output logic             rej_o
);
  localparam logic [XW-1:0] LAST = XW'(LINE_PIX - 1);

  logic [PIX_W-1:0] mem [LINE_PIX];
  logic [XW-1:0]    ptr_q, ptr_d;
  logic             full_q, full_d;
  logic             rej_q;
  logic             take;

  assign take = wr_en_i && !full_q;

  always_comb begin
    ptr_d  = ptr_q;
    full_d = full_q;
    if (release_i) begin
      ptr_d  = '0;
      full_d = 1'b0;
    end else if (take) begin
      if (ptr_q == LAST) begin
        ptr_d  = '0;
        full_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
      rej_q  <= wr_en_i && full_q;
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[ptr_q] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];
  assign full_o    = full_q;
  assign rej_o     = rej_q;
endmodule

// File: rtl/cam_gap_timer.sv
module cam_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] len_i,
  output logic             expire_o
);
  logic [GAP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = len_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == GAP_W'(1));
endmodule

// File: rtl/cam_xy_count.sv
module cam_xy_count #(
  parameter int LINE_PIX = 752,
  parameter int ROWS     = 480,
  localparam int XW      = $clog2(LINE_PIX),
  localparam int YW      = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          row_end_o
);
  localparam logic [XW-1:0] LAST_X = XW'(LINE_PIX - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(ROWS - 1);

  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;

  assign row_end_o = adv_i && (x_q == LAST_X);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (adv_i) begin
      if (x_q == LAST_X) begin
        x_d = '0;
        y_d = (y_q == LAST_Y) ? '0 : y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
endmodule

// File: rtl/cam_line_replay.sv
module cam_line_replay
  import cam_pkg::*;
#(
  parameter int LINE_PIX = 752,
  parameter int ROWS     = 480,
  parameter int PIX_W    = 8,
  parameter int GAP_W    = 16,
  localparam int XW      = $clog2(LINE_PIX),
  localparam int YW      = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_data,
  output logic             wr_rej_o,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             single_i,
  input  logic [GAP_W-1:0] gap_cfg_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pclk_o,
  output logic             rsync_o,
  output logic             fsync_o,
  output logic [XW-1:0]    x_o,
  output logic [YW-1:0]    y_o,
  output logic [1:0]       state_o
);
  cam_st_e st_q, st_d;
  logic    run_q, run_d;
  logic    one_q, one_d;
  logic    ph_q, ph_d;
  logic    full, row_end, gap_exp, go_emit, emit, gap_load;
  logic [XW-1:0] x;
  logic [YW-1:0] y;

  assign emit     = (st_q == ST_EMIT);
  assign go_emit  = (st_q == ST_WAIT) && full && (run_q || one_q);
  assign gap_load = row_end && (gap_cfg_i != '0);

  cam_linebuf #(.LINE_PIX(LINE_PIX), .PIX_W(PIX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .release_i(row_end), .rd_idx_i(x), .rd_data_o(pix_o),
    .full_o(full), .rej_o(wr_rej_o)
  );

  cam_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load_i(gap_load), .len_i(gap_cfg_i),
    .expire_o(gap_exp)
  );

  cam_xy_count #(.LINE_PIX(LINE_PIX), .ROWS(ROWS)) u_xy (
    .clk(clk), .rst_n(rst_n), .adv_i(emit && ph_q),
    .x_o(x), .y_o(y), .row_end_o(row_end)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT: if (go_emit) st_d = ST_EMIT;
      ST_EMIT: if (row_end) st_d = (gap_cfg_i == '0) ? ST_WAIT : ST_GAP;
      ST_GAP:  if (gap_exp) st_d = ST_WAIT;
      default: st_d = ST_WAIT;
    endcase
    run_d = stop_i ? 1'b0 : (start_i ? 1'b1 : run_q);
    if (stop_i)        one_d = 1'b0;
    else if (single_i) one_d = 1'b1;
    else if (go_emit)  one_d = 1'b0;
    else               one_d = one_q;
    ph_d = emit ? ~ph_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      run_q <= 1'b0;
      one_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      one_q <= one_d;
      ph_q  <= ph_d;
    end
  end

  assign pclk_o  = emit && ph_q;
  assign rsync_o = emit;
  assign fsync_o = emit && (x == '0) && (y == '0);
  assign x_o     = x;
  assign y_o     = y;
  assign state_o = st_q;
endmodule

// File: rtl/cam_line_replay_chk.sv
module cam_line_replay_chk #(
  parameter int LINE_PIX = 752,
  parameter int ROWS     = 480,
  parameter int PIX_W    = 8,
  localparam int XW      = $clog2(LINE_PIX),
  localparam int YW      = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_rej_o,
  input logic [PIX_W-1:0] pix_o,
  input logic             pclk_o,
  input logic             rsync_o,
  input logic             fsync_o,
  input logic [XW-1:0]    x_o,
  input logic [YW-1:0]    y_o,
  input logic [1:0]       state_o
);
  // R5
  fsync_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> (rsync_o && x_o == '0 && y_o == '0));

  // R4
  pclk_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_o |-> rsync_o);

  // R3
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsync_o && !pclk_o) |=> (pclk_o && $stable(pix_o) && $stable(x_o)));

  // R8
  rej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rej_o |-> $past(wr_en));

  // R12
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(x_o) < LINE_PIX) && (int'(y_o) < ROWS));

  // R12
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> !rsync_o);
endmodule

bind cam_line_replay cam_line_replay_chk #(
  .LINE_PIX(LINE_PIX), .ROWS(ROWS), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rej_o(wr_rej_o),
  .pix_o(pix_o), .pclk_o(pclk_o), .rsync_o(rsync_o), .fsync_o(fsync_o),
  .x_o(x_o), .y_o(y_o), .state_o(state_o)
);

// File: tb/sim_cam_line_replay.sv
module sim_cam_line_replay;
  localparam int LP = 4;
  localparam int RW = 2;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic start_i = 1'b0, stop_i = 1'b0, single_i = 1'b0;
  logic [GW-1:0] gap_cfg_i = '0;
  logic wr_rej_o, pclk_o, rsync_o, fsync_o;
  logic [7:0] pix_o;
  logic [1:0] x_o;
  logic [0:0] y_o;
  logic [1:0] state_o;

  int n_run = 0, n_fail = 0, row = 0;

  always #2 clk = ~clk;

  cam_line_replay #(.LINE_PIX(LP), .ROWS(RW), .PIX_W(8), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_rej_o(wr_rej_o), .start_i(start_i), .stop_i(stop_i),
    .single_i(single_i), .gap_cfg_i(gap_cfg_i), .pix_o(pix_o),
    .pclk_o(pclk_o), .rsync_o(rsync_o), .fsync_o(fsync_o),
    .x_o(x_o), .y_o(y_o), .state_o(state_o)
  );

  // {gap[3:0], pixel3, pixel2, pixel1, pixel0}
  localparam logic [35:0] VEC [4] = '{
    {4'd2, 32'hA3A2A1A0},
    {4'd0, 32'h00FF00FF},
    {4'd3, 32'h12345678},
    {4'd1, 32'hFFFFFFFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_line(input logic [31:0] px);
    for (int i = 0; i < LP; i++) wr_byte(px[8*i +: 8]);
  endtask

  task automatic pulse_start();  start_i = 1'b1;  @(negedge clk); start_i = 1'b0;  endtask
  task automatic pulse_stop();   stop_i = 1'b1;   @(negedge clk); stop_i = 1'b0;   endtask
  task automatic pulse_single(); single_i = 1'b1; @(negedge clk); single_i = 1'b0; endtask

  task automatic grab(input int exp_y, input logic [31:0] exp_px);
    int t = 0;
    int k = 0;
    logic [31:0] got = '0;
    bit pat = 1'b1, fs = 1'b1;
    while (!rsync_o && t < 200) begin @(negedge clk); t++; end
    while (rsync_o && k < 100) begin
      if (pclk_o !== k[0]) pat = 1'b0;
      if (int'(x_o) != k / 2) pat = 1'b0;
      if (int'(y_o) != exp_y) pat = 1'b0;
      if (fsync_o !== 1'(exp_y == 0 && k < 2)) fs = 1'b0;
      if (pclk_o && k < 2 * LP) got[8*(k/2) +: 8] = pix_o;
      k++;
      @(negedge clk);
    end
    chk(got == exp_px, "R3 pixel values in write order", int'(got), int'(exp_px));
    chk(k == 2 * LP, "R4 rsync_o width", k, 2 * LP);
    chk(pat, "R3 pclk/x_o pattern (R11 row index)", int'(pat), 1);
    chk(fs, "R5 fsync_o only at origin pixel (R11 frame wrap)", int'(fs), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!rsync_o && !fsync_o && !pclk_o, "R1 flags after reset", {rsync_o, fsync_o, pclk_o}, 0);
    chk(x_o == 0 && y_o == 0, "R1 position after reset", {x_o, y_o}, 0);
    chk(state_o == 2'd0, "R1 state after reset", state_o, 0);

    pulse_start();
    // R2: partial line must not play
    gap_cfg_i = 4'd1;
    for (int i = 0; i < LP - 1; i++) wr_byte(8'h10 + 8'(i));
    seen = 1'b0;
    repeat (10) begin @(negedge clk); if (rsync_o) seen = 1'b1; end
    chk(!seen, "R2 no output on partial line", seen, 0);
    wr_byte(8'h13);
    // R7: two cycles after the completing write
    chk(!rsync_o, "R7 rsync_o low one cycle after last write", rsync_o, 0);
    @(negedge clk);
    chk(rsync_o, "R7 rsync_o rises two cycles after last write", rsync_o, 1);
    grab(row % RW, 32'h13121110); row++;

    // table walk: lines written in the gap of the previous one
    for (int v = 0; v < 4; v++) begin
      gap_cfg_i = VEC[v][35:32];
      write_line(VEC[v][31:0]);
      grab(row % RW, VEC[v][31:0]);
      row++;
    end
    // R11: five lines, two rows per frame
    chk(x_o == 0 && int'(y_o) == row % RW, "R11 x_o/y_o after wrap", {x_o, y_o}, row % RW);

    // R9: halted playback holds a complete line
    pulse_stop();
    write_line(32'h5A6B7C8D);
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (rsync_o) seen = 1'b1; end
    chk(!seen, "R9 stop withholds lines", seen, 0);
    chk(state_o == 2'd0, "R12 state waiting", state_o, 0);
    // R8: write against a full buffer
    wr_byte(8'hEE);
    chk(wr_rej_o, "R8 refused write flagged", wr_rej_o, 1);
    @(negedge clk);
    chk(!wr_rej_o, "R8 flag is one cycle", wr_rej_o, 0);
    // R10: one line on single; content unchanged (R8)
    pulse_single();
    grab(row % RW, 32'h5A6B7C8D); row++;
    write_line(32'h11223344);
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (rsync_o) seen = 1'b1; end
    chk(!seen, "R10 single plays only one line", seen, 0);

    // R6: gap with next line written during the gap
    gap_cfg_i = 4'd10;
    pulse_start();
    grab(row % RW, 32'h11223344); row++;
    chk(state_o == 2'd2, "R12 state in gap", state_o, 2);
    n = 0;
    fork
      write_line(32'h99AABBCC);
      begin
        while (!rsync_o && n < 100) begin n++; @(negedge clk); end
      end
    join
    chk(n == 11, "R6 low time equals gap plus one", n, 11);
    grab(row % RW, 32'h99AABBCC); row++;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule